// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It owns the clock-enable pin and the command, bank and address pins from reset until the memory is ready for normal traffic. It works through the mandatory bring-up order on its own and then raises a ready flag so that the normal command scheduler can take over the pins. First it holds clock enable low through a long settling interval. It then precharges all banks, turns the DLL on through the extended mode register, and loads the base mode register with the DLL reset bit set. After that it precharges again and runs two auto refreshes. Last, it loads the base mode register again with the DLL reset bit cleared.

Every wait is a parameter counted in clock cycles. The settling interval is computed from a microsecond figure and the clock period in picoseconds. The precharge, mode-load and refresh gaps are cycle counts set directly, as is the DLL lock interval. Two input words supply the operating mode: one for the base mode register and one for the extended mode register. The sequencer sets the DLL control bits itself and passes the other bits through unchanged.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, `cke` is 0, `init_done` is 0, and the command pins {cs_n,ras_n,cas_n,we_n} carry NOP (4'b0111). A reset applied partway through the sequence restarts it from the beginning.
- R2: After reset is released, `cke` stays low for PWRUP_CYC cycles, where PWRUP_CYC = ceil(PWRUP_US*1e6/CLK_PERIOD_PS). It rises in cycle PWRUP_CYC, counting the first clock edge after release as cycle 1, and it stays high until the next reset. No command other than NOP is issued while `cke` is low.
- R3: After `cke` rises, exactly one NOP cycle follows. Then PRECHARGE ALL (4'b0010) is issued with bank 0 and only address bit AP_BIT (default 10) set.
- R4: T_RP cycles after the first precharge, a mode load (4'b0000) goes to bank 2'b01 (the extended mode register). Its address is `ext_mode_word` with bit DLL_DIS_BIT (default 0) forced to 0, which enables the DLL.
- R5: T_MRD cycles after the extended load, a mode load goes to bank 2'b00. Its address is `mode_word` with bit DLL_RST_BIT (default 8) forced to 1, which resets the DLL.
- R6: T_MRD cycles after the DLL-reset load, PRECHARGE ALL is issued. T_RP cycles later comes the first AUTO REFRESH (4'b0001, bank 0, address 0). The second AUTO REFRESH follows T_RFC cycles after the first.
- R7: T_RFC cycles after the second refresh, a mode load goes to bank 2'b00 with `mode_word` and bit DLL_RST_BIT forced to 0.
- R8: Exactly seven non-NOP commands are issued per run. Every other cycle after reset carries NOP with bank and address driven to 0.
- R9: `init_done` rises one cycle after the later of two points: the end of the T_MRD wait after the final load, and DLL_LOCK_CYC cycles after the DLL-reset load. It then stays high until reset.
- R10: After `init_done` is high, changes on `mode_word` and `ext_mode_word` have no effect. The pins keep NOP with address and bank 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | ROW_W | Base mode register operating bits |
| ext_mode_word | input | ROW_W | Extended mode register operating bits |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Address bus |
| init_done | output | 1 | Sequence complete, pins handed to scheduler |

## Verification
The bench predicts the exact issue cycle of every command from the wait parameters. A sequencer with an off-by-one wait would issue a command one cycle early or late, and a missing or doubled step would show up as an unexpected or absent command. Two word pairs are used, one with the DLL reset bit already set in the input and one with it clear, so that a design that copied the bit through instead of forcing it would load the wrong word in R5 or R7. With the default gaps the DLL lock interval dominates, so a design that raised the ready flag after the final mode wait alone would be about two hundred cycles early. A reset partway through the sequence checks that the restart repeats the full settling interval instead of resuming.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // Pin order: {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR   = 4'b0000,
      CMD_REF   = 4'b0001,
      CMD_PRE   = 4'b0010,
      CMD_NOP   = 4'b0111,
      CMD_DESEL = 4'b1111
   } cmd_t;

   typedef enum logic [4:0] {
      ST_PWRUP,
      ST_CKE,
      ST_PRE1,
      ST_W_PRE1,
      ST_EMR,
      ST_W_EMR,
      ST_MRS_RST,
      ST_W_MRS_RST,
      ST_PRE2,
      ST_W_PRE2,
      ST_REF1,
      ST_W_REF1,
      ST_REF2,
      ST_W_REF2,
      ST_MRS,
      ST_W_MRS,
      ST_DLL_WAIT,
      ST_DONE
   } step_t;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int WIDTH   = 16,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic             zero
);

   logic [WIDTH-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= WIDTH'(RST_VAL);
      else if (load)
         count <= load_val;
      else if (count != '0)
         count <= count - 1'b1;
   end

   assign zero = (count == '0);

   // Timer must saturate at zero, never wrapping into a fresh wait
   assert_zero_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero);

   // Each idle cycle removes exactly one cycle from the pending wait
   assert_counts_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero && !load) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
   import ddr_init_pkg::*;
#(
   parameter int ROW_W       = 13,
   parameter int BA_W        = 2,
   parameter int DLL_RST_BIT = 8,
   parameter int DLL_DIS_BIT = 0,
   parameter int AP_BIT      = 10
) (
   input  step_t            step,
   input  logic [ROW_W-1:0] mode_word,
   input  logic [ROW_W-1:0] ext_mode_word,
   output cmd_t             cmd,
   output logic [BA_W-1:0]  ba,
   output logic [ROW_W-1:0] addr
);

   localparam logic [ROW_W-1:0] RST_MASK = ROW_W'(1) << DLL_RST_BIT;
   localparam logic [ROW_W-1:0] DIS_MASK = ROW_W'(1) << DLL_DIS_BIT;
   localparam logic [ROW_W-1:0] AP_MASK  = ROW_W'(1) << AP_BIT;
   localparam logic [BA_W-1:0]  BA_BASE  = BA_W'(0);
   localparam logic [BA_W-1:0]  BA_EXT   = BA_W'(1);

   always_comb begin
      cmd  = CMD_NOP;
      ba   = '0;
      addr = '0;
      unique case (step)
         ST_PRE1, ST_PRE2: begin
            cmd  = CMD_PRE;
            addr = AP_MASK;
         end
         ST_EMR: begin
            cmd  = CMD_LMR;
            ba   = BA_EXT;
            addr = ext_mode_word & ~DIS_MASK;
         end
         ST_MRS_RST: begin
            cmd  = CMD_LMR;
            ba   = BA_BASE;
            addr = mode_word | RST_MASK;
         end
         ST_MRS: begin
            cmd  = CMD_LMR;
            ba   = BA_BASE;
            addr = mode_word & ~RST_MASK;
         end
         ST_REF1, ST_REF2: cmd = CMD_REF;
         default: ;
      endcase
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int ROW_W         = 13,
   parameter int BA_W          = 2,
   parameter int CLK_PERIOD_PS = 10000,
   parameter int PWRUP_US      = 200,
   parameter int T_RP          = 3,
   parameter int T_MRD         = 2,
   parameter int T_RFC         = 8,
   parameter int DLL_LOCK_CYC  = 200,
   parameter int DLL_RST_BIT   = 8,
   parameter int DLL_DIS_BIT   = 0,
   parameter int AP_BIT        = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] mode_word,
   input  logic [ROW_W-1:0] ext_mode_word,
   output logic             cke,
   output logic             cs_n,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [BA_W-1:0]  ba,
   output logic [ROW_W-1:0] addr,
   output logic             init_done
);

   localparam int PWRUP_CYC = (PWRUP_US * 1000000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
   localparam int GAP_MAX1  = (T_RP > T_MRD) ? T_RP : T_MRD;
   localparam int GAP_MAX   = (GAP_MAX1 > T_RFC) ? GAP_MAX1 : T_RFC;
   localparam int STEP_MAX  = (PWRUP_CYC > GAP_MAX) ? PWRUP_CYC : GAP_MAX;
   localparam int STEP_W    = $clog2(STEP_MAX + 1);
   localparam int DLL_W     = $clog2(DLL_LOCK_CYC + 1);

   // Elaboration-time parameter checks
   if (T_RP < 2 || T_MRD < 2 || T_RFC < 2) begin : g_bad_gap
      $error("command gaps must be at least two cycles");
   end
   if (DLL_LOCK_CYC < 1 || PWRUP_CYC < 2) begin : g_bad_wait
      $error("power-up and DLL waits must be positive");
   end
   if (DLL_RST_BIT >= ROW_W || DLL_DIS_BIT >= ROW_W || AP_BIT >= ROW_W) begin : g_bad_bit
      $error("control bit positions exceed address width");
   end
   if (BA_W < 2) begin : g_bad_ba
      $error("bank address must be at least two bits");
   end

   step_t             step_q, step_d;
   logic              step_load;
   logic [STEP_W-1:0] step_val;
   logic              step_zero;
   logic              dll_load;
   logic              dll_zero;
   cmd_t              cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= ST_PWRUP;
      else        step_q <= step_d;
   end

   // Next step: command steps last one cycle, wait steps end on timer zero
   always_comb begin
      step_d = step_q;
      unique case (step_q)
         ST_PWRUP:     if (step_zero) step_d = ST_CKE;
         ST_CKE:       step_d = ST_PRE1;
         ST_PRE1:      step_d = ST_W_PRE1;
         ST_W_PRE1:    if (step_zero) step_d = ST_EMR;
         ST_EMR:       step_d = ST_W_EMR;
         ST_W_EMR:     if (step_zero) step_d = ST_MRS_RST;
         ST_MRS_RST:   step_d = ST_W_MRS_RST;
         ST_W_MRS_RST: if (step_zero) step_d = ST_PRE2;
         ST_PRE2:      step_d = ST_W_PRE2;
         ST_W_PRE2:    if (step_zero) step_d = ST_REF1;
         ST_REF1:      step_d = ST_W_REF1;
         ST_W_REF1:    if (step_zero) step_d = ST_REF2;
         ST_REF2:      step_d = ST_W_REF2;
         ST_W_REF2:    if (step_zero) step_d = ST_MRS;
         ST_MRS:       step_d = ST_W_MRS;
         ST_W_MRS:     if (step_zero) step_d = ST_DLL_WAIT;
         ST_DLL_WAIT:  if (dll_zero) step_d = ST_DONE;
         ST_DONE:      step_d = ST_DONE;
         default:      step_d = ST_PWRUP;
      endcase
   end

   // Gap timer: loaded on a command cycle with (gap - 2)
   always_comb begin
      step_load = 1'b1;
      step_val  = '0;
      unique case (step_q)
         ST_PRE1, ST_PRE2:           step_val = STEP_W'(T_RP - 2);
         ST_EMR, ST_MRS_RST, ST_MRS: step_val = STEP_W'(T_MRD - 2);
         ST_REF1, ST_REF2:           step_val = STEP_W'(T_RFC - 2);
         default:                    step_load = 1'b0;
      endcase
   end

   ddr_init_timer #(
      .WIDTH   (STEP_W),
      .RST_VAL (PWRUP_CYC - 1)
   ) u_step_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (step_load),
      .load_val (step_val),
      .zero     (step_zero)
   );

   // DLL lock timer runs alongside the rest of the sequence
   assign dll_load = (step_q == ST_MRS_RST);

   ddr_init_timer #(
      .WIDTH   (DLL_W),
      .RST_VAL (0)
   ) u_dll_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dll_load),
      .load_val (DLL_W'(DLL_LOCK_CYC - 1)),
      .zero     (dll_zero)
   );

   ddr_init_cmd_enc #(
      .ROW_W       (ROW_W),
      .BA_W        (BA_W),
      .DLL_RST_BIT (DLL_RST_BIT),
      .DLL_DIS_BIT (DLL_DIS_BIT),
      .AP_BIT      (AP_BIT)
   ) u_cmd_enc (
      .step          (step_q),
      .mode_word     (mode_word),
      .ext_mode_word (ext_mode_word),
      .cmd           (cmd),
      .ba            (ba),
      .addr          (addr)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign cke       = (step_q != ST_PWRUP);
   assign init_done = (step_q == ST_DONE);

   assert_no_cmd_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

   assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   assert_done_after_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> dll_zero);

   assert_done_pins_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP && addr == '0 && ba == '0));

   assert_single_cmd_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ({cs_n, ras_n, cas_n, we_n} != CMD_NOP) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

   localparam int CLK_PERIOD_NS = 10;
   localparam int ROW_W   = 13;
   localparam int BA_W    = 2;
   localparam int PS      = 10000;
   localparam int US      = 200;
   localparam int T_RP    = 3;
   localparam int T_MRD   = 2;
   localparam int T_RFC   = 8;
   localparam int DLL_LCK = 200;
   localparam int P_CYC   = (US * 1000000 + PS - 1) / PS;

   typedef struct {
      logic [3:0]       cmd;
      logic [BA_W-1:0]  ba;
      logic [ROW_W-1:0] addr;
      int               cyc;
      string            req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [ROW_W-1:0] mode_word = '0;
   logic [ROW_W-1:0] ext_mode_word = '0;
   logic             cke, cs_n, ras_n, cas_n, we_n, init_done;
   logic [BA_W-1:0]  ba;
   logic [ROW_W-1:0] addr;

   exp_t sb_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   int   cyc = 0;
   int   done_exp = 0;
   bit   cke_seen = 0;
   bit   done_seen = 0;
   bit   finished = 0;

   always #(CLK_PERIOD_NS / 2) clk = ~clk;

   ddr_init_seq #(
      .ROW_W (ROW_W), .BA_W (BA_W), .CLK_PERIOD_PS (PS), .PWRUP_US (US),
      .T_RP (T_RP), .T_MRD (T_MRD), .T_RFC (T_RFC), .DLL_LOCK_CYC (DLL_LCK)
   ) u_ddr_init_seq (
      .clk (clk), .rst_n (rst_n), .mode_word (mode_word), .ext_mode_word (ext_mode_word),
      .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
      .ba (ba), .addr (addr), .init_done (init_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // Driver: queue the expected schedule for one run
   task automatic push_run(input logic [ROW_W-1:0] mw, input logic [ROW_W-1:0] ew);
      int t_pre1, t_emr, t_rst, t_pre2, t_ref1, t_ref2, t_mrs, a, b;
      t_pre1 = P_CYC + 1;
      t_emr  = t_pre1 + T_RP;
      t_rst  = t_emr + T_MRD;
      t_pre2 = t_rst + T_MRD;
      t_ref1 = t_pre2 + T_RP;
      t_ref2 = t_ref1 + T_RFC;
      t_mrs  = t_ref2 + T_RFC;
      sb_q.delete();
      sb_q.push_back('{4'b0010, 2'b00, 13'h0400, t_pre1, "R3"});
      sb_q.push_back('{4'b0000, 2'b01, ew & ~13'h0001, t_emr, "R4"});
      sb_q.push_back('{4'b0000, 2'b00, mw | 13'h0100, t_rst, "R5"});
      sb_q.push_back('{4'b0010, 2'b00, 13'h0400, t_pre2, "R6"});
      sb_q.push_back('{4'b0001, 2'b00, 13'h0000, t_ref1, "R6"});
      sb_q.push_back('{4'b0001, 2'b00, 13'h0000, t_ref2, "R6"});
      sb_q.push_back('{4'b0000, 2'b00, mw & ~13'h0100, t_mrs, "R7"});
      a = t_mrs + T_MRD;
      b = t_rst + DLL_LCK;
      done_exp = ((a > b) ? a : b) + 1;
      cke_seen  = 0;
      done_seen = 0;
   endtask

   // Monitor: compare every non-NOP command against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (cke && !cke_seen) begin
            cke_seen = 1;
            chk(cyc == P_CYC, "R2", "cke rise cycle", cyc, P_CYC);
         end
         if (cke_seen && !cke) chk(0, "R2", "cke fell", 0, 1);
         if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
            if (sb_q.size() == 0) begin
               chk(0, "R8", "unexpected command", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk({cs_n, ras_n, cas_n, we_n} == e.cmd, e.req, "command", {cs_n, ras_n, cas_n, we_n}, e.cmd);
               chk(ba == e.ba, e.req, "bank", ba, e.ba);
               chk(addr == e.addr, e.req, "address", addr, e.addr);
               chk(cyc == e.cyc, e.req, "issue cycle", cyc, e.cyc);
            end
         end else if (addr != '0 || ba != '0) begin
            chk(0, "R8", "NOP with nonzero address/bank", addr, 0);
         end
         if (init_done && !done_seen) begin
            done_seen = 1;
            chk(cyc == done_exp, "R9", "init_done rise cycle", cyc, done_exp);
         end
         if (done_seen && !init_done) chk(0, "R9", "init_done fell", 0, 1);
      end
   end

   task automatic check_reset_state();
      chk(cke == 1'b0, "R1", "cke in reset", cke, 0);
      chk(init_done == 1'b0, "R1", "init_done in reset", init_done, 0);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "command in reset",
          {cs_n, ras_n, cas_n, we_n}, 4'b0111);
   endtask

   task automatic finish_run();
      chk(sb_q.size() == 0, "R8", "commands left unissued", sb_q.size(), 0);
      chk(done_seen, "R9", "init_done seen", done_seen, 1);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      // Run A: DLL reset bit set in the input, DLL disable bit set in ext word
      mode_word = 13'h0132; ext_mode_word = 13'h0003;
      push_run(13'h0132, 13'h0003);
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      wait (cyc == done_exp + 5);
      @(negedge clk);
      // R10: input changes after completion are ignored
      mode_word = 13'h1FFF; ext_mode_word = 13'h1FFF;
      repeat (10) @(negedge clk);
      chk(addr == '0 && ba == '0, "R10", "pins after input change", addr, 0);
      chk(init_done == 1'b1, "R10", "init_done after input change", init_done, 1);
      finish_run();

      // Run B: reset partway through, sequence must restart
      rst_n = 1'b0;
      mode_word = 13'h0071; ext_mode_word = 13'h0000;
      push_run(13'h0071, 13'h0000);
      repeat (2) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      wait (cyc == P_CYC + 10);
      @(negedge clk);
      rst_n = 1'b0;
      push_run(13'h0071, 13'h0000);
      repeat (2) @(negedge clk);
      check_reset_state();

      // Run C: full run with the second word pair
      rst_n = 1'b1;
      wait (cyc == done_exp + 5);
      repeat (2) @(negedge clk);
      finish_run();
      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, done_exp);
      report();
   end

endmodule